// File: doc/BRIEF.md
# Packet Transfer Phase Sequencer

This block runs the MAC side of one channel of the handshake between an Ethernet MAC and a DMA-style memory access layer. A channel can carry either receive or transmit traffic. The block steps through three phases: idle, packet and status. A FRAME output marks the packet phase. Each packet phase starts with a single command write, in which the DMA side gives the control word for that packet. Data beats can move only after that write. The beats flow from a source port to a sink port through a small beat buffer.

In transmit, the DMA side drives the source port and the MAC datapath takes the sink port. In receive, the two sides swap. The phase logic is the same in both cases. When the sink side takes the beat flagged as last, FRAME drops and the status phase begins. The block then holds a status request with a frozen status word until the DMA side acknowledges it.

After the acknowledge the channel returns to idle. The exception is multiple transfer mode with another packet waiting: there the channel reopens FRAME at once and skips idle.

Top module: `pkt_phase_seq`

## Requirements
- R1: On synchronous reset the channel is idle, and `frame`, `stat_req`, `src_rdy`, `snk_vld` and `proto_err` are all low.
- R2: While idle, `frame`, `stat_req`, `src_rdy` and `snk_vld` stay low. Pulses on `cmd_we`, `stat_ack` or `src_vld` change no state, leave `cmd_out` unchanged and raise no `proto_err`.
- R3: When `pkt_pending` is high at a clock edge while idle, `frame` goes high in the next cycle, and not before.
- R4: The first `cmd_we` sampled while `frame` is high loads `cmd_data` into `cmd_out`, visible the next cycle. `cmd_out` then holds until the next accepted command.
- R5: In the packet phase, `src_rdy` and `snk_vld` stay low until the command write has been accepted.
- R6: Beats taken at the source (`src_vld` and `src_rdy` high) leave the sink in the same order, with the same data and last flag. Up to `FIFO_DEPTH` beats can be buffered, and `snk_vld` is never high with the buffer empty.
- R7: `frame` stays high through the packet phase. It goes low in the cycle after the sink accepts the beat with `snk_last` = 1.
- R8: `stat_req` rises in the same cycle that `frame` falls. `stat_word` then shows the value `stat_in` had at that clock edge.
- R9: `stat_req` stays high and `stat_word` stays stable until `stat_ack` is sampled high. `stat_req` is low in the next cycle.
- R10: If `multi_mode` and `pkt_pending` are both high at the acknowledge edge, `frame` is high in the next cycle and idle is skipped. Otherwise the channel goes idle.
- R11: A `cmd_we` while `frame` is high after the command was accepted, or during the status phase, leaves `cmd_out` unchanged. It raises `proto_err` for exactly the next cycle.
- R12: Once the source has delivered its last-flagged beat, `src_rdy` stays low for the rest of that packet phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_pending | input | 1 | Another packet is waiting to start |
| multi_mode | input | 1 | Skip idle between back-to-back packets |
| frame | output | 1 | High for the whole packet phase |
| cmd_we | input | 1 | Command write strobe from the DMA side |
| cmd_data | input | CMD_W | Per-packet control word |
| cmd_out | output | CMD_W | Latched control word toward the MAC datapath |
| src_vld | input | 1 | Source beat valid |
| src_data | input | DATA_W | Source beat data |
| src_last | input | 1 | Source beat is the last of the packet |
| src_rdy | output | 1 | Block takes the source beat |
| snk_vld | output | 1 | Sink beat valid |
| snk_data | output | DATA_W | Sink beat data |
| snk_last | output | 1 | Sink beat is the last of the packet |
| snk_rdy | input | 1 | Sink takes the beat |
| stat_in | input | STAT_W | Status value from the MAC datapath |
| stat_req | output | 1 | Status read request toward the DMA side |
| stat_word | output | STAT_W | Frozen status word |
| stat_ack | input | 1 | Status has been read |
| proto_err | output | 1 | One-cycle pulse on a misplaced command write |

## Verification
A phase register in the wrong state shows at the ports within one cycle. FRAME and the status request would overlap, or one of them would rise without its trigger, or the data handshakes would open before the command. A lost last-beat flag shows up as FRAME staying high after the final sink beat, which is caught on the very next cycle. A status word that is captured too late or not held shows as a mismatch or a change while the request waits for an acknowledge. A wrong branch on the multiple-transfer decision shows in the FRAME value one cycle after the acknowledge.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PACKET = 2'd1,
    PH_STATUS = 2'd2
  } phase_e;
endpackage

// File: rtl/pps_capture_reg.sv
// Holding register loaded on a strobe; used for the command and status words.
module pps_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pps_beat_fifo.sv
// Small beat buffer; storage has no reset so it maps onto distributed RAM.
module pps_beat_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (cnt == FULL_CNT);
  assign empty    = (cnt == '0);
endmodule

// File: rtl/pps_ctrl.sv
// Phase sequencer: idle -> packet (command, then data) -> status -> idle/packet.
module pps_ctrl
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pkt_pending,
  input  logic multi_mode,
  input  logic cmd_we,
  input  logic src_vld,
  input  logic src_last,
  input  logic snk_rdy,
  input  logic head_last,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic stat_ack,
  output logic frame,
  output logic stat_req,
  output logic src_rdy,
  output logic snk_vld,
  output logic push,
  output logic pop,
  output logic cmd_load,
  output logic stat_load,
  output logic proto_err
);
  phase_e state_q, state_d;
  logic   cmd_seen_q, last_in_q;
  logic   in_pkt, in_stat, xfer_en, last_out, cmd_bad, enter_pkt;

  assign in_pkt   = (state_q == PH_PACKET);
  assign in_stat  = (state_q == PH_STATUS);
  assign xfer_en  = in_pkt && cmd_seen_q;
  assign src_rdy  = xfer_en && !last_in_q && !fifo_full;
  assign snk_vld  = xfer_en && !fifo_empty;
  assign push     = src_vld && src_rdy;
  assign pop      = snk_vld && snk_rdy;
  assign last_out = pop && head_last;
  assign cmd_load = cmd_we && in_pkt && !cmd_seen_q;
  assign cmd_bad  = cmd_we && ((in_pkt && cmd_seen_q) || in_stat);
  assign stat_load = in_pkt && last_out;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:   if (pkt_pending) state_d = PH_PACKET;
      PH_PACKET: if (last_out)    state_d = PH_STATUS;
      PH_STATUS: if (stat_ack)    state_d = (multi_mode && pkt_pending) ? PH_PACKET : PH_IDLE;
      default:                    state_d = PH_IDLE;
    endcase
  end

  assign enter_pkt = (state_d == PH_PACKET) && !in_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PH_IDLE;
      frame      <= 1'b0;
      stat_req   <= 1'b0;
      cmd_seen_q <= 1'b0;
      last_in_q  <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      state_q   <= state_d;
      frame     <= (state_d == PH_PACKET);
      stat_req  <= (state_d == PH_STATUS);
      proto_err <= cmd_bad;
      if (enter_pkt) begin
        cmd_seen_q <= 1'b0;
        last_in_q  <= 1'b0;
      end else begin
        if (cmd_load)           cmd_seen_q <= 1'b1;
        if (push && src_last)   last_in_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_phase_seq.sv
module pkt_phase_seq #(
  parameter int DATA_W     = 8,
  parameter int CMD_W      = 8,
  parameter int STAT_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_pending,
  input  logic              multi_mode,
  output logic              frame,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [CMD_W-1:0]  cmd_out,
  input  logic              src_vld,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic              src_rdy,
  output logic              snk_vld,
  output logic [DATA_W-1:0] snk_data,
  output logic              snk_last,
  input  logic              snk_rdy,
  input  logic [STAT_W-1:0] stat_in,
  output logic              stat_req,
  output logic [STAT_W-1:0] stat_word,
  input  logic              stat_ack,
  output logic              proto_err
);
  localparam int BEAT_W = DATA_W + 1;

  logic push, pop, fifo_full, fifo_empty, cmd_load, stat_load;
  logic [BEAT_W-1:0] head;

  pps_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pkt_pending(pkt_pending),
    .multi_mode (multi_mode),
    .cmd_we     (cmd_we),
    .src_vld    (src_vld),
    .src_last   (src_last),
    .snk_rdy    (snk_rdy),
    .head_last  (head[DATA_W]),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .stat_ack   (stat_ack),
    .frame      (frame),
    .stat_req   (stat_req),
    .src_rdy    (src_rdy),
    .snk_vld    (snk_vld),
    .push       (push),
    .pop        (pop),
    .cmd_load   (cmd_load),
    .stat_load  (stat_load),
    .proto_err  (proto_err)
  );

  pps_beat_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_data({src_last, src_data}),
    .pop      (pop),
    .pop_data (head),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  pps_capture_reg #(.W(CMD_W)) i_cmd_reg (
    .clk (clk),
    .rst (rst),
    .load(cmd_load),
    .d   (cmd_data),
    .q   (cmd_out)
  );

  pps_capture_reg #(.W(STAT_W)) i_stat_reg (
    .clk (clk),
    .rst (rst),
    .load(stat_load),
    .d   (stat_in),
    .q   (stat_word)
  );

  assign snk_data = head[DATA_W-1:0];
  assign snk_last = head[DATA_W];
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame,
  input logic              stat_req,
  input logic              stat_ack,
  input logic [STAT_W-1:0] stat_word,
  input logic              src_rdy,
  input logic              snk_vld,
  input logic              snk_rdy,
  input logic              snk_last,
  input logic              pkt_pending,
  input logic              multi_mode,
  input logic              cmd_we,
  input logic              proto_err
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!frame && !stat_req) |-> (!src_rdy && !snk_vld));

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!frame && !stat_req && pkt_pending) |=> frame);

  p_cmd_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame) |-> (!src_rdy && !snk_vld));

  p_sink_in_pkt_r6: assert property (@(posedge clk) disable iff (rst)
    snk_vld |-> frame);

  p_frame_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (frame && snk_vld && snk_rdy && snk_last) |=> !frame);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(frame && stat_req));

  p_stat_enter_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(frame) |-> stat_req);

  p_stat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_req && !stat_ack) |=> (stat_req && $stable(stat_word)));

  p_stat_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_req && stat_ack) |=> !stat_req);

  p_skip_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_req && stat_ack && multi_mode && pkt_pending) |=> frame);

  p_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(cmd_we));
endmodule

bind pkt_phase_seq pps_seq_chk #(.STAT_W(STAT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .frame      (frame),
  .stat_req   (stat_req),
  .stat_ack   (stat_ack),
  .stat_word  (stat_word),
  .src_rdy    (src_rdy),
  .snk_vld    (snk_vld),
  .snk_rdy    (snk_rdy),
  .snk_last   (snk_last),
  .pkt_pending(pkt_pending),
  .multi_mode (multi_mode),
  .cmd_we     (cmd_we),
  .proto_err  (proto_err)
);

// File: tb/test_pkt_phase_seq.sv
`timescale 1ns/1ps
module test_pkt_phase_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_pending = 0, multi_mode = 0, cmd_we = 0, src_vld = 0, src_last = 0;
  logic stat_ack = 0, snk_rdy = 1'b1;
  logic [7:0] cmd_data = '0, src_data = '0, stat_in = '0;
  logic frame, src_rdy, snk_vld, snk_last, stat_req, proto_err;
  logic [7:0] cmd_out, snk_data, stat_word;

  int  n_chk = 0, n_fail = 0;
  int  rx_n = 0, exp_n = 0;
  logic [7:0] exp_base = '0, exp_stat = '0;
  bit  stall_en = 0, last_seen = 0;

  always #2.5 clk = ~clk;

  pkt_phase_seq i_pkt_phase_seq (
    .clk(clk), .rst(rst), .pkt_pending(pkt_pending), .multi_mode(multi_mode),
    .frame(frame), .cmd_we(cmd_we), .cmd_data(cmd_data), .cmd_out(cmd_out),
    .src_vld(src_vld), .src_data(src_data), .src_last(src_last), .src_rdy(src_rdy),
    .snk_vld(snk_vld), .snk_data(snk_data), .snk_last(snk_last), .snk_rdy(snk_rdy),
    .stat_in(stat_in), .stat_req(stat_req), .stat_word(stat_word),
    .stat_ack(stat_ack), .proto_err(proto_err)
  );

  // {multi[21], stall[20], beats[19:16], cmd[15:8], stat[7:0]}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd3, 8'hA1, 8'h11},
    {1'b1, 1'b1, 4'd8, 8'hB2, 8'h22},
    {1'b1, 1'b0, 4'd1, 8'hC3, 8'h33},
    {1'b0, 1'b1, 4'd5, 8'hD4, 8'h44},
    {1'b0, 1'b0, 4'd4, 8'hE5, 8'h55},
    {1'b1, 1'b0, 4'd2, 8'hF6, 8'h66}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // sink side: alternate ready when stalling
  always @(posedge clk) begin
    #1;
    snk_rdy <= stall_en ? ~snk_rdy : 1'b1;
  end

  // sink monitor, sampled half a cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (last_seen) begin
        chk(frame == 1'b0, "R7 frame low after last sink beat", frame, 0);
        chk(stat_req == 1'b1, "R8 stat_req with frame fall", stat_req, 1);
        chk(stat_word == exp_stat, "R8 stat_word captured", stat_word, exp_stat);
        last_seen = 0;
      end
      if (snk_vld && snk_rdy) begin
        chk(frame == 1'b1, "R7 frame high during data", frame, 1);
        chk(snk_data == exp_base + 8'(rx_n), "R6 beat order", snk_data, exp_base + 8'(rx_n));
        chk(snk_last == (rx_n == exp_n - 1), "R6 last flag", snk_last, rx_n == exp_n - 1);
        if (snk_last) last_seen = 1;
        rx_n++;
      end
    end
  end

  task automatic wait_frame();
    do @(negedge clk); while (!frame);
  endtask

  task automatic write_cmd(input logic [7:0] c);
    step(); cmd_we = 1; cmd_data = c;
    @(negedge clk);
    step(); cmd_we = 0;
    @(negedge clk);
  endtask

  task automatic send_beats(input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      bit acc;
      step();
      src_vld = 1; src_data = base + 8'(k); src_last = (k == n - 1);
      do begin
        @(negedge clk); acc = src_rdy;
        if (!acc) step();
      end while (!acc);
    end
    step();
    src_vld = 1; src_data = 8'hEE; src_last = 0;
    forever begin
      @(negedge clk);
      if (!frame) break;
      chk(src_rdy == 1'b0, "R12 source closed after last", src_rdy, 0);
      step();
    end
    src_vld = 0;
    chk(rx_n == n, "R6 beat count", rx_n, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(frame == 0, "R1 frame", frame, 0);
    chk(stat_req == 0, "R1 stat_req", stat_req, 0);
    chk(src_rdy == 0 && snk_vld == 0, "R1 data handshakes", {src_rdy, snk_vld}, 0);
    chk(proto_err == 0, "R1 proto_err", proto_err, 0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      bit exp_frame;
      v = VEC[i];
      step();
      multi_mode = v[21]; stall_en = v[20]; pkt_pending = 1;
      stat_in = v[7:0]; exp_stat = v[7:0];
      exp_base = 8'(i * 16); exp_n = int'(v[19:16]); rx_n = 0;
      wait_frame();
      chk(src_rdy == 0 && snk_vld == 0, "R5 closed before command", {src_rdy, snk_vld}, 0);
      write_cmd(v[15:8]);
      chk(cmd_out == v[15:8], "R4 command latched", cmd_out, v[15:8]);
      send_beats(exp_n, exp_base);
      step();
      pkt_pending = (i < NV - 1); stat_in = ~v[7:0];
      @(negedge clk);
      chk(stat_req == 1, "R9 request held", stat_req, 1);
      step();
      @(negedge clk);
      chk(stat_word == v[7:0], "R9 status word stable", stat_word, v[7:0]);
      step(); stat_ack = 1;
      @(negedge clk);
      step(); stat_ack = 0; stall_en = 0;
      @(negedge clk);
      exp_frame = v[21] && (i < NV - 1);
      chk(stat_req == 0, "R9 request drops after ack", stat_req, 0);
      chk(frame == exp_frame, "R10 idle skip decision", frame, exp_frame);
    end

    // idle ignores active inputs
    step(); cmd_we = 1; cmd_data = 8'h5A; stat_ack = 1; src_vld = 1;
    @(negedge clk);
    step(); cmd_we = 0; stat_ack = 0; src_vld = 0;
    @(negedge clk);
    chk(frame == 0 && stat_req == 0, "R2 idle outputs", {frame, stat_req}, 0);
    chk(src_rdy == 0 && snk_vld == 0, "R2 idle data", {src_rdy, snk_vld}, 0);
    chk(proto_err == 0, "R2 no error in idle", proto_err, 0);
    chk(cmd_out == 8'hF6, "R2 command ignored in idle", cmd_out, 8'hF6);

    // start timing, gating and misplaced commands
    step(); pkt_pending = 1; multi_mode = 1;
    @(negedge clk);
    chk(frame == 0, "R3 frame not early", frame, 0);
    step(); pkt_pending = 0;
    @(negedge clk);
    chk(frame == 1, "R3 frame one cycle after pending", frame, 1);
    chk(src_rdy == 0, "R5 no data without command", src_rdy, 0);
    step();
    @(negedge clk);
    chk(src_rdy == 0, "R5 still closed", src_rdy, 0);
    step(); cmd_we = 1; cmd_data = 8'h33;
    @(negedge clk);
    step(); cmd_data = 8'h44;
    @(negedge clk);
    chk(cmd_out == 8'h33, "R4 first command taken", cmd_out, 8'h33);
    step(); cmd_we = 0;
    @(negedge clk);
    chk(proto_err == 1, "R11 second command flagged", proto_err, 1);
    chk(cmd_out == 8'h33, "R11 second command dropped", cmd_out, 8'h33);
    step();
    @(negedge clk);
    chk(proto_err == 0, "R11 single-cycle pulse", proto_err, 0);
    stat_in = 8'h99; exp_stat = 8'h99; exp_base = 8'h70; exp_n = 1; rx_n = 0;
    send_beats(1, 8'h70);
    step(); cmd_we = 1; cmd_data = 8'h55;
    @(negedge clk);
    step(); cmd_we = 0;
    @(negedge clk);
    chk(proto_err == 1, "R11 command in status flagged", proto_err, 1);
    chk(cmd_out == 8'h33 && stat_req == 1, "R11 status command dropped", cmd_out, 8'h33);
    step(); stat_ack = 1;
    @(negedge clk);
    step(); stat_ack = 0;
    @(negedge clk);
    chk(frame == 0 && stat_req == 0, "R10 idle without pending", {frame, stat_req}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule